// File: doc/BRIEF.md
# Real-Mode Exception Detector and Vector Selector

This block sits next to a small 16-bit real-mode processor core and looks at every instruction as it retires. From the decoded instruction class, the opcode bytes, the addressing-mode field, the divider status, the overflow and trace flags, the operands of the range check and a strap that says whether a coprocessor is fitted, it decides whether a fault or a trap has to be taken. When one is taken, it reports the vector number (0 to 7), the physical address of that vector's table entry and the return address that the core must push.

The core gives the result of one instruction per cycle, marked by `retireValid`. All results are registered and appear one cycle later. `excTake` is a single-cycle strobe. For faults, `commitInhibit` rises with the strobe, and the core must then discard that instruction's architectural writes. Traps and conditional instructions whose condition is false commit normally.

The stack push, the flag save and the fetch from the handler belong to the core.

Top module: `rmExcUnit`

## Requirements
- R1: With class code 1 (divide), a set `divZero` or `divOverflow` raises vector 0. The return address is `instrStart`, which includes the prefix bytes, and `commitInhibit` is high.
- R2: With `traceFlag` high and no fault on the instruction, vector 1 is raised. The return address is `instrNext` and there is no inhibit.
- R3: With class code 0 (plain), an opcode byte 0xCC, or 0xCD followed by 0x03, raises vector 3 with return address `instrNext`. 0xCD followed by any other byte raises nothing.
- R4: With class code 2 (overflow check) and `ovFlag` high, vector 4 is raised with return address `instrNext`. With `ovFlag` low, the instruction is a no-op and no strobe is given.
- R5: With class code 3 (range check) and a memory operand, the comparison is signed. A `boundValue` below `boundLow` or above `boundHigh` raises vector 5 with return address `instrStart` and inhibit. A value equal to either bound does not trap.
- R6: Vector 6 is raised, with return address `instrStart` and inhibit, in two cases: class code 5 (undefined opcode), and class code 3 or 6 (memory-only instructions) when `modField` is 2'b11.
- R7: With class code 4 (coprocessor escape) and `fpuPresent` low, vector 7 is raised with return address `instrStart` and inhibit. With `fpuPresent` high, nothing is raised.
- R8: `excTableAddr` equals the vector times 4, zero-extended, which is an address in segment 0.
- R9: `excTake` is high for exactly one cycle, in the cycle after a retiring instruction that raised a cause. It stays low when `retireValid` is low, whatever the other inputs are.
- R10: `commitInhibit` is high only together with a strobe for vectors 0, 5, 6 and 7. It is low for traps and in cycles without a strobe.
- R11: Priority order: a fault beats every trap. Traps 3 and 4 beat the trace trap.
- R12: While reset is held, `excTake`, `commitInhibit`, `excVector`, `excTableAddr` and `excReturnAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction retires this cycle |
| instrClass | input | 3 | Decoded class code (see R1 to R7; code 7 acts as plain without breakpoint detection) |
| opByte0 | input | 8 | First opcode byte |
| opByte1 | input | 8 | Second opcode byte |
| modField | input | 2 | Addressing mode field; 2'b11 means register operand |
| instrStart | input | 16 | Address of the first byte, prefixes included |
| instrNext | input | 16 | Address of the following instruction |
| divZero | input | 1 | Divisor was zero |
| divOverflow | input | 1 | Quotient does not fit the destination |
| ovFlag | input | 1 | Overflow flag |
| traceFlag | input | 1 | Trace flag |
| boundValue | input | 16 | Signed register value under the range check |
| boundLow | input | 16 | Signed lower limit |
| boundHigh | input | 16 | Signed upper limit |
| fpuPresent | input | 1 | Coprocessor fitted strap |
| excTake | output | 1 | One-cycle exception strobe |
| excVector | output | 3 | Vector number |
| excTableAddr | output | 20 | Physical address of the vector table entry |
| excReturnAddr | output | 16 | Return address to push |
| commitInhibit | output | 1 | Discard the retiring instruction's writes (faults only) |

## Verification
The assertions assume four things about the inputs:
- `retireValid` is low during reset.
- `instrStart` and `instrNext` are stable through the retiring cycle.
- At most one class code applies to any instruction.
- The divider status bits matter only for class 1.

The stimulus follows these assumptions. It changes inputs only shortly after a rising edge, and it releases reset with `retireValid` low. Each retiring instruction carries fresh, distinct start and next addresses, so that a wrong choice of return address can be seen. Idle cycles hold `traceFlag` and the other cause inputs active while `retireValid` is low.

// File: rtl/rmexc_pkg.sv
package rmexc_pkg;

  typedef enum logic [2:0] {
    CLS_PLAIN   = 3'd0,
    CLS_DIV     = 3'd1,
    CLS_INTO    = 3'd2,
    CLS_BOUND   = 3'd3,
    CLS_ESC     = 3'd4,
    CLS_UNDEF   = 3'd5,
    CLS_MEMONLY = 3'd6,
    CLS_RSVD    = 3'd7
  } instrClass_e;

  localparam int VEC_W = 3;

  localparam logic [VEC_W-1:0] VEC_DIV   = 3'd0;
  localparam logic [VEC_W-1:0] VEC_TRACE = 3'd1;
  localparam logic [VEC_W-1:0] VEC_BRK   = 3'd3;
  localparam logic [VEC_W-1:0] VEC_OVF   = 3'd4;
  localparam logic [VEC_W-1:0] VEC_RANGE = 3'd5;
  localparam logic [VEC_W-1:0] VEC_UNDEF = 3'd6;
  localparam logic [VEC_W-1:0] VEC_NOFPU = 3'd7;

  localparam logic [7:0] OP_BRK1   = 8'hCC;
  localparam logic [7:0] OP_INTN   = 8'hCD;
  localparam logic [7:0] OP_BRKIMM = 8'h03;
  localparam logic [1:0] MOD_REG   = 2'b11;

  // Strobes passed from the control block to the datapath
  typedef struct packed {
    logic             fire;
    logic             useStart;
    logic             isFault;
    logic [VEC_W-1:0] vec;
  } excCtl_t;

endpackage

// File: rtl/rmExcControl.sv
module rmExcControl
  import rmexc_pkg::*;
(
  input  logic        retireValid,
  input  instrClass_e instrClass,
  input  logic [7:0]  opByte0,
  input  logic [7:0]  opByte1,
  input  logic [1:0]  modField,
  input  logic        divZero,
  input  logic        divOverflow,
  input  logic        ovFlag,
  input  logic        traceFlag,
  input  logic        fpuPresent,
  input  logic        boundOutside,
  output excCtl_t     ctl
);

  logic regOperand;
  logic faultDiv;
  logic faultUndef;
  logic faultRange;
  logic faultEsc;
  logic trapBrk;
  logic trapOvf;

  always_comb begin
    regOperand = (modField == MOD_REG);
    faultDiv   = (instrClass == CLS_DIV) && (divZero || divOverflow);
    faultUndef = (instrClass == CLS_UNDEF) ||
                 (((instrClass == CLS_BOUND) || (instrClass == CLS_MEMONLY)) && regOperand);
    faultRange = (instrClass == CLS_BOUND) && !regOperand && boundOutside;
    faultEsc   = (instrClass == CLS_ESC) && !fpuPresent;
    trapBrk    = (instrClass == CLS_PLAIN) &&
                 ((opByte0 == OP_BRK1) || ((opByte0 == OP_INTN) && (opByte1 == OP_BRKIMM)));
    trapOvf    = (instrClass == CLS_INTO) && ovFlag;
  end

  // Priority: faults, then the instruction's own traps, then trace
  always_comb begin
    ctl = '0;
    if (retireValid) begin
      if (faultDiv) begin
        ctl = '{fire: 1'b1, useStart: 1'b1, isFault: 1'b1, vec: VEC_DIV};
      end else if (faultUndef) begin
        ctl = '{fire: 1'b1, useStart: 1'b1, isFault: 1'b1, vec: VEC_UNDEF};
      end else if (faultRange) begin
        ctl = '{fire: 1'b1, useStart: 1'b1, isFault: 1'b1, vec: VEC_RANGE};
      end else if (faultEsc) begin
        ctl = '{fire: 1'b1, useStart: 1'b1, isFault: 1'b1, vec: VEC_NOFPU};
      end else if (trapBrk) begin
        ctl = '{fire: 1'b1, useStart: 1'b0, isFault: 1'b0, vec: VEC_BRK};
      end else if (trapOvf) begin
        ctl = '{fire: 1'b1, useStart: 1'b0, isFault: 1'b0, vec: VEC_OVF};
      end else if (traceFlag) begin
        ctl = '{fire: 1'b1, useStart: 1'b0, isFault: 1'b0, vec: VEC_TRACE};
      end
    end
  end

endmodule

// File: rtl/rmExcDatapath.sv
module rmExcDatapath
  import rmexc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] instrStart,
  input  logic [ADDR_W-1:0] instrNext,
  input  logic [ADDR_W-1:0] boundValue,
  input  logic [ADDR_W-1:0] boundLow,
  input  logic [ADDR_W-1:0] boundHigh,
  input  excCtl_t           ctl,
  output logic              boundOutside,
  output logic              excTake,
  output logic [VEC_W-1:0]  excVector,
  output logic [PHYS_W-1:0] excTableAddr,
  output logic [ADDR_W-1:0] excReturnAddr,
  output logic              commitInhibit
);

  localparam int ENTRY_SHIFT = 2;
  localparam int PAD_W       = PHYS_W - VEC_W - ENTRY_SHIFT;

  logic [PHYS_W-1:0] tableNext;

  always_comb begin
    boundOutside = ($signed(boundValue) < $signed(boundLow)) ||
                   ($signed(boundValue) > $signed(boundHigh));
    tableNext    = {{PAD_W{1'b0}}, ctl.vec, {ENTRY_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excTake       <= 1'b0;
      commitInhibit <= 1'b0;
      excVector     <= '0;
      excTableAddr  <= '0;
      excReturnAddr <= '0;
    end else begin
      excTake       <= ctl.fire;
      commitInhibit <= ctl.fire && ctl.isFault;
      if (ctl.fire) begin
        excVector     <= ctl.vec;
        excTableAddr  <= tableNext;
        excReturnAddr <= ctl.useStart ? instrStart : instrNext;
      end
    end
  end

  // R9: the strobe follows a cycle in which the control raised a cause
  a_r9_strobe_follows_cause: assert property (@(posedge clk) disable iff (!rstN)
    excTake |-> $past(ctl.fire));

  // R10: inhibit only together with a fault vector
  a_r10_inhibit_only_faults: assert property (@(posedge clk) disable iff (!rstN)
    commitInhibit |-> (excTake && (excVector == VEC_DIV || excVector == VEC_RANGE ||
                                   excVector == VEC_UNDEF || excVector == VEC_NOFPU)));

  // R2: a trace trap returns to the following instruction
  a_r2_trace_returns_next: assert property (@(posedge clk) disable iff (!rstN)
    (excTake && excVector == VEC_TRACE) |-> (excReturnAddr == $past(instrNext) && !commitInhibit));

  // R1: a divide fault returns to the divide instruction itself and inhibits commit
  a_r1_div_returns_start: assert property (@(posedge clk) disable iff (!rstN)
    (excTake && excVector == VEC_DIV) |-> (excReturnAddr == $past(instrStart) && commitInhibit));

endmodule

// File: rtl/rmExcUnit.sv
module rmExcUnit
  import rmexc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [2:0]        instrClass,
  input  logic [7:0]        opByte0,
  input  logic [7:0]        opByte1,
  input  logic [1:0]        modField,
  input  logic [ADDR_W-1:0] instrStart,
  input  logic [ADDR_W-1:0] instrNext,
  input  logic              divZero,
  input  logic              divOverflow,
  input  logic              ovFlag,
  input  logic              traceFlag,
  input  logic [ADDR_W-1:0] boundValue,
  input  logic [ADDR_W-1:0] boundLow,
  input  logic [ADDR_W-1:0] boundHigh,
  input  logic              fpuPresent,
  output logic              excTake,
  output logic [2:0]        excVector,
  output logic [PHYS_W-1:0] excTableAddr,
  output logic [ADDR_W-1:0] excReturnAddr,
  output logic              commitInhibit
);

  excCtl_t ctl;
  logic    boundOutside;

  rmExcControl u_ctrl (
    .retireValid  (retireValid),
    .instrClass   (instrClass_e'(instrClass)),
    .opByte0      (opByte0),
    .opByte1      (opByte1),
    .modField     (modField),
    .divZero      (divZero),
    .divOverflow  (divOverflow),
    .ovFlag       (ovFlag),
    .traceFlag    (traceFlag),
    .fpuPresent   (fpuPresent),
    .boundOutside (boundOutside),
    .ctl          (ctl)
  );

  rmExcDatapath #(
    .ADDR_W (ADDR_W),
    .PHYS_W (PHYS_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .instrStart    (instrStart),
    .instrNext     (instrNext),
    .boundValue    (boundValue),
    .boundLow      (boundLow),
    .boundHigh     (boundHigh),
    .ctl           (ctl),
    .boundOutside  (boundOutside),
    .excTake       (excTake),
    .excVector     (excVector),
    .excTableAddr  (excTableAddr),
    .excReturnAddr (excReturnAddr),
    .commitInhibit (commitInhibit)
  );

endmodule

// File: tb/tb_rmExcUnit.sv
`timescale 1ns/100ps
module tb_rmExcUnit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        retireValid;
  logic [2:0]  instrClass;
  logic [7:0]  opByte0, opByte1;
  logic [1:0]  modField;
  logic [15:0] instrStart, instrNext;
  logic        divZero, divOverflow, ovFlag, traceFlag, fpuPresent;
  logic [15:0] boundValue, boundLow, boundHigh;
  logic        excTake, commitInhibit;
  logic [2:0]  excVector;
  logic [19:0] excTableAddr;
  logic [15:0] excReturnAddr;

  always #2.5 clk = ~clk;

  rmExcUnit dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .instrClass(instrClass),
    .opByte0(opByte0), .opByte1(opByte1), .modField(modField),
    .instrStart(instrStart), .instrNext(instrNext),
    .divZero(divZero), .divOverflow(divOverflow), .ovFlag(ovFlag), .traceFlag(traceFlag),
    .boundValue(boundValue), .boundLow(boundLow), .boundHigh(boundHigh),
    .fpuPresent(fpuPresent), .excTake(excTake), .excVector(excVector),
    .excTableAddr(excTableAddr), .excReturnAddr(excReturnAddr), .commitInhibit(commitInhibit)
  );

  typedef struct {
    int          due;
    bit          take;
    logic [2:0]  vec;
    logic [15:0] ret;
    bit          inh;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seqNo  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: applies one retiring instruction and predicts the result from the requirements
  task automatic issue(input string tag, input logic [2:0] cls, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [1:0] md, input logic dz,
                       input logic dov, input logic ov, input logic tr, input logic fpu,
                       input logic [15:0] bv, input logic [15:0] bl, input logic [15:0] bh);
    expItem_t e;
    logic [15:0] st, nx;
    bit regOp, fDiv, fUnd, fRng, fEsc, tBrk, tOvf;
    @(posedge clk); #1;
    seqNo++;
    st = 16'h1000 + 16'(seqNo * 16);
    nx = st + 16'd3;
    retireValid = 1'b1; instrClass = cls; opByte0 = b0; opByte1 = b1; modField = md;
    instrStart = st; instrNext = nx; divZero = dz; divOverflow = dov; ovFlag = ov;
    traceFlag = tr; fpuPresent = fpu; boundValue = bv; boundLow = bl; boundHigh = bh;
    regOp = (md == 2'b11);
    fDiv  = (cls == 3'd1) && (dz || dov);
    fUnd  = (cls == 3'd5) || (((cls == 3'd3) || (cls == 3'd6)) && regOp);
    fRng  = (cls == 3'd3) && !regOp && (($signed(bv) < $signed(bl)) || ($signed(bv) > $signed(bh)));
    fEsc  = (cls == 3'd4) && !fpu;
    tBrk  = (cls == 3'd0) && ((b0 == 8'hCC) || (b0 == 8'hCD && b1 == 8'h03));
    tOvf  = (cls == 3'd2) && ov;
    e.due = cyc + 1; e.tag = tag; e.take = 1'b1; e.inh = 1'b1; e.ret = st; e.vec = 3'd0;
    if (fDiv)        e.vec = 3'd0;
    else if (fUnd)   e.vec = 3'd6;
    else if (fRng)   e.vec = 3'd5;
    else if (fEsc)   e.vec = 3'd7;
    else begin
      e.inh = 1'b0; e.ret = nx;
      if (tBrk)      e.vec = 3'd3;
      else if (tOvf) e.vec = 3'd4;
      else if (tr)   e.vec = 3'd1;
      else           e.take = 1'b0;
    end
    scoreQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      retireValid = 1'b0; traceFlag = 1'b1; instrClass = 3'd1; divZero = 1'b1; opByte0 = 8'hCC;
    end
  endtask

  // Monitor: pops the item due this cycle and compares; otherwise expects no strobe (R9)
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (scoreQ.size() > 0 && scoreQ[0].due == cyc) begin
        expItem_t e;
        e = scoreQ.pop_front();
        checks++;
        if (e.take) begin
          if (excTake !== 1'b1 || excVector !== e.vec || excReturnAddr !== e.ret ||
              commitInhibit !== e.inh || excTableAddr !== 20'(e.vec) * 20'd4) begin
            fails++;
            $display("FAIL %s: take=%b vec=%0d ret=%h inh=%b tbl=%h, expected take=1 vec=%0d ret=%h inh=%b tbl=%h (R8)",
                     e.tag, excTake, excVector, excReturnAddr, commitInhibit, excTableAddr,
                     e.vec, e.ret, e.inh, 20'(e.vec) * 20'd4);
          end
        end else if (excTake !== 1'b0 || commitInhibit !== 1'b0) begin
          fails++;
          $display("FAIL %s: take=%b inh=%b, expected take=0 inh=0", e.tag, excTake, commitInhibit);
        end
      end else begin
        checks++;
        if (excTake !== 1'b0 || commitInhibit !== 1'b0) begin
          fails++;
          $display("FAIL R9 idle: take=%b inh=%b, expected take=0 inh=0", excTake, commitInhibit);
        end
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; retireValid = 1'b0; instrClass = 3'd0; opByte0 = 8'h90; opByte1 = 8'h00;
    modField = 2'b00; instrStart = 16'h0; instrNext = 16'h0; divZero = 1'b0;
    divOverflow = 1'b0; ovFlag = 1'b0; traceFlag = 1'b0; fpuPresent = 1'b1;
    boundValue = 16'h0; boundLow = 16'h0; boundHigh = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (excTake !== 1'b0 || commitInhibit !== 1'b0 || excVector !== 3'd0 ||
        excTableAddr !== 20'd0 || excReturnAddr !== 16'd0) begin
      fails++;
      $display("FAIL R12 reset: take=%b inh=%b vec=%0d tbl=%h ret=%h, expected all zero",
               excTake, commitInhibit, excVector, excTableAddr, excReturnAddr);
    end
    @(posedge clk); #1 rstN = 1'b1;

    // R1 divide faults
    issue("R1 div zero",        3'd1, 8'hF7, 8'hF0, 2'b11, 1, 0, 0, 0, 1, 0, 0, 0);
    issue("R1 div overflow",    3'd1, 8'hF7, 8'hF0, 2'b11, 0, 1, 0, 0, 1, 0, 0, 0);
    issue("R1 div clean",       3'd1, 8'hF7, 8'hF0, 2'b11, 0, 0, 0, 0, 1, 0, 0, 0);
    // R2 trace
    issue("R2 trace plain",     3'd0, 8'h90, 8'h00, 2'b00, 0, 0, 0, 1, 1, 0, 0, 0);
    issue("R11 div over trace", 3'd1, 8'hF7, 8'hF0, 2'b11, 1, 0, 0, 1, 1, 0, 0, 0);
    // R3 breakpoints
    issue("R3 one-byte brk",    3'd0, 8'hCC, 8'h00, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R3 two-byte brk",    3'd0, 8'hCD, 8'h03, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R3 other int",       3'd0, 8'hCD, 8'h21, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R11 brk over trace", 3'd0, 8'hCC, 8'h00, 2'b00, 0, 0, 0, 1, 1, 0, 0, 0);
    // R4 overflow check
    issue("R4 ovf set",         3'd2, 8'hCE, 8'h00, 2'b00, 0, 0, 1, 0, 1, 0, 0, 0);
    issue("R4 ovf clear",       3'd2, 8'hCE, 8'h00, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R4 noop then trace", 3'd2, 8'hCE, 8'h00, 2'b00, 0, 0, 0, 1, 1, 0, 0, 0);
    issue("R11 ovf over trace", 3'd2, 8'hCE, 8'h00, 2'b00, 0, 0, 1, 1, 1, 0, 0, 0);
    // R5 signed range check
    issue("R5 below",           3'd3, 8'h62, 8'h00, 2'b00, 0, 0, 0, 0, 1, 16'hFFF0, 16'hFFFB, 16'h0003);
    issue("R5 above",           3'd3, 8'h62, 8'h00, 2'b00, 0, 0, 0, 0, 1, 16'h0004, 16'hFFFB, 16'h0003);
    issue("R5 equal low",       3'd3, 8'h62, 8'h00, 2'b00, 0, 0, 0, 0, 1, 16'hFFFB, 16'hFFFB, 16'h0003);
    issue("R5 equal high",      3'd3, 8'h62, 8'h00, 2'b00, 0, 0, 0, 0, 1, 16'h0003, 16'hFFFB, 16'h0003);
    issue("R5 signed inside",   3'd3, 8'h62, 8'h00, 2'b00, 0, 0, 0, 0, 1, 16'hFFFF, 16'hFFFB, 16'h0003);
    issue("R5 most negative",   3'd3, 8'h62, 8'h00, 2'b10, 0, 0, 0, 0, 1, 16'h8000, 16'hFFFB, 16'h0003);
    issue("R11 range vs trace", 3'd3, 8'h62, 8'h00, 2'b00, 0, 0, 0, 1, 1, 16'h7FFF, 16'hFFFB, 16'h0003);
    // R6 undefined and register-operand misuse
    issue("R6 undefined",       3'd5, 8'h0F, 8'hFF, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R6 memonly reg",     3'd6, 8'hC4, 8'hC0, 2'b11, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R6 memonly mem",     3'd6, 8'hC4, 8'h06, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R6 range reg op",    3'd3, 8'h62, 8'hC0, 2'b11, 0, 0, 0, 0, 1, 16'h0100, 16'h0000, 16'h0010);
    // R7 coprocessor
    issue("R7 no fpu",          3'd4, 8'hD9, 8'hC0, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    issue("R7 fpu present",     3'd4, 8'hD9, 8'hC0, 2'b11, 0, 0, 0, 0, 1, 0, 0, 0);
    // R9 retire low ignores active cause inputs
    idle(3);
    issue("R10 trap no inhibit",3'd0, 8'hCD, 8'h03, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R9 back to back",    3'd4, 8'hD9, 8'hC0, 2'b11, 0, 0, 0, 1, 0, 0, 0, 0);
    idle(4);
    @(posedge clk); #1 traceFlag = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule